// File: doc/BRIEF.md
# Serial Control-Register Port

This block is a four-wire serial slave that gives an external host read and write access to a small bank of byte-wide control registers. The host pulls chip select low and toggles a serial clock. On each rising edge the block samples one data bit. Every byte travels least significant bit first. The first byte of a transaction is a command: its top bit selects the direction (1 writes, 0 reads) and its low five bits give the starting register address. Bits 6 and 5 of the command byte are don't-care.

In a write transaction, each byte after the command is stored at the current address. For each stored byte the block emits a one-cycle strobe carrying the address and the data, so that neighbouring logic can react. In a read transaction, the current register is shifted out on the serial data output, changing on falling serial clock edges; the serial data input is ignored during a read. In both directions the address advances after every complete data byte and wraps from 31 to 0.

Nine writable registers (0 to 8) have fixed reset defaults. Two read-only identity registers sit at 9 and 10. Addresses 11 to 31 read as zero, and writes to addresses 9 to 31 are dropped. The serial inputs are resynchronised into the system clock domain, so the serial clock must run well below the system clock.

Top module: `sreg_port`

## Requirements
- R1: After reset, a read returns register 0 = FDh, register 1 = C0h and registers 2 to 8 = 00h. The serial output is 0 and the write strobe is low.
- R2: The first byte after chip select falls is a command, received LSB first. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 4:0 give the start address, and bits 6:5 have no effect.
- R3: In write mode, each complete data byte to an address of 8 or less gives exactly one single-cycle strobe, carrying that address and the byte. The address then advances by one and wraps from 31 to 0.
- R4: In read mode, the register at the current address appears on the serial output LSB first. The output changes only on falling serial clock edges, so it is valid at the next rising edge. The address advances after each byte, the serial input is ignored, and no write occurs.
- R5: Register 9 reads 19h and register 10 reads 13h. Addresses 11 to 31 read 00h. Writes to addresses 9 to 31 produce no strobe and change no readback value.
- R6: Chip select rising at any point discards a partial byte. The next byte after chip select falls again is treated as a command.
- R7: While chip select is high, serial clock and data activity cause no write.
- R8: The serial output is 0 whenever chip select is high, and whenever the transaction is not in a read data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock from the host, idle high |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 5 | Address of the strobed write |
| reg_wdata | output | 8 | Data of the strobed write |

## Verification
A bit counter that is off by one shifts every following byte. This shows up at the ports within the same transaction, as write data with the wrong value or strobes at the wrong addresses. A direction flag or address register in the wrong state shows up in the first data byte: it causes spurious strobes, missing strobes, or read bytes that do not match the shadow model. If chip select fails to clear the state, the next transaction shows a misaligned command, and this is caught by aborting partial bytes and then writing a known address.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;

    // Reset value of each writable register, by index.
    function automatic logic [7:0] rst_value(input int unsigned idx);
        case (idx)
            0:       return 8'hFD;
            1:       return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int unsigned       WIDTH   = 3,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int unsigned        ADDR_W = 5,
    parameter int unsigned        DATA_W = 8,
    parameter int unsigned        NUM_RW = 9,
    parameter logic [DATA_W-1:0]  ID_HI  = 8'h19,
    parameter logic [DATA_W-1:0]  ID_LO  = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] ID_HI_ADDR = ADDR_W'(NUM_RW);
    localparam logic [ADDR_W-1:0] ID_LO_ADDR = ADDR_W'(NUM_RW + 1);

    logic [DATA_W-1:0] regs_d [NUM_RW];
    logic [DATA_W-1:0] regs_q [NUM_RW];

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
            always_comb begin
                regs_d[g] = regs_q[g];
                if (wr_en && wr_addr == ADDR_W'(g)) regs_d[g] = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= DATA_W'(rst_value(g));
                else        regs_q[g] <= regs_d[g];
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_addr == ID_HI_ADDR) begin
            rd_data = ID_HI;
        end else if (rd_addr == ID_LO_ADDR) begin
            rd_data = ID_LO;
        end else begin
            for (int r = 0; r < NUM_RW; r++) begin
                if (rd_addr == ADDR_W'(r)) rd_data = regs_q[r];
            end
        end
    end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
    import sreg_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 5,
    parameter int unsigned        DATA_W      = 8,
    parameter int unsigned        NUM_RW      = 9,
    parameter logic [DATA_W-1:0]  ID_HI       = 8'h19,
    parameter logic [DATA_W-1:0]  ID_LO       = 8'h13,
    parameter int unsigned        SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_csn,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int unsigned BIT_CW = $clog2(DATA_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DATA_W - 1);

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   addr;
        logic [BIT_CW-1:0]   bitcnt;
        logic [DATA_W-2:0]   rx;
        logic [DATA_W-2:0]   tx;
        logic                so;
        logic                sck_prev;
        logic                wr;
        logic [ADDR_W-1:0]   wr_addr;
        logic [DATA_W-1:0]   wr_data;
    } state_t;

    // Synchronised inputs: {csn, sck, din}; idle levels csn=1, sck=1.
    logic [2:0] sync_q;
    logic       cs_act, sck_lvl, din_lvl, sck_rise, sck_fall;
    logic [DATA_W-1:0] rd_data, byte_in;
    state_t s_d, s_q;

    sreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_csn, ser_clk, ser_din}),
        .q     (sync_q)
    );

    assign cs_act   = ~sync_q[2];
    assign sck_lvl  = sync_q[1];
    assign din_lvl  = sync_q[0];
    assign sck_rise = sck_lvl & ~s_q.sck_prev;
    assign sck_fall = ~sck_lvl & s_q.sck_prev;
    assign byte_in  = {din_lvl, s_q.rx};

    sreg_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_RW (NUM_RW),
        .ID_HI  (ID_HI),
        .ID_LO  (ID_LO)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (s_q.wr),
        .wr_addr (s_q.wr_addr),
        .wr_data (s_q.wr_data),
        .rd_addr (s_q.addr),
        .rd_data (rd_data)
    );

    always_comb begin
        s_d          = s_q;
        s_d.wr       = 1'b0;
        s_d.sck_prev = sck_lvl;
        if (!cs_act) begin
            s_d.phase  = PH_CMD;
            s_d.bitcnt = '0;
            s_d.so     = 1'b0;
        end else begin
            if (sck_rise) begin
                s_d.rx     = byte_in[DATA_W-1:1];
                s_d.bitcnt = s_q.bitcnt + 1'b1;
                if (s_q.bitcnt == LAST_BIT) begin
                    s_d.bitcnt = '0;
                    case (s_q.phase)
                        PH_CMD: begin
                            s_d.phase = byte_in[DATA_W-1] ? PH_WRITE : PH_READ;
                            s_d.addr  = byte_in[ADDR_W-1:0];
                        end
                        PH_WRITE: begin
                            if (s_q.addr < ADDR_W'(NUM_RW)) begin
                                s_d.wr      = 1'b1;
                                s_d.wr_addr = s_q.addr;
                                s_d.wr_data = byte_in;
                            end
                            s_d.addr = s_q.addr + 1'b1;
                        end
                        default: begin
                            s_d.addr = s_q.addr + 1'b1;
                        end
                    endcase
                end
            end
            if (sck_fall) begin
                if (s_q.phase == PH_READ) begin
                    if (s_q.bitcnt == '0) begin
                        s_d.so = rd_data[0];
                        s_d.tx = rd_data[DATA_W-1:1];
                    end else begin
                        s_d.so = s_q.tx[0];
                        s_d.tx = {1'b0, s_q.tx[DATA_W-2:1]};
                    end
                end else begin
                    s_d.so = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.phase    <= PH_CMD;
            s_q.sck_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_dout  = s_q.so;
    assign reg_wr    = s_q.wr;
    assign reg_addr  = s_q.wr_addr;
    assign reg_wdata = s_q.wr_data;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned NUM_RW = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              sck_fall,
    input logic              ser_dout,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr
);
    // R3: a strobe lasts a single cycle (bytes are many cycles apart)
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5: no strobe ever reaches a read-only or unimplemented address
    a_r5_strobe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_addr < ADDR_W'(NUM_RW)));

    // R7: no write follows a cycle with chip select inactive
    a_r7_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !reg_wr);

    // R8: serial output returns low when chip select is inactive
    a_r8_dout_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !ser_dout);

    // R4: serial output changes only after a falling serial clock edge
    a_r4_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sck_fall) |=> $stable(ser_dout));
endmodule

bind sreg_port sreg_port_chk #(.ADDR_W(ADDR_W), .NUM_RW(NUM_RW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sck_fall (sck_fall),
    .ser_dout (ser_dout),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr)
);

// File: tb/test_sreg_port.sv
module test_sreg_port;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csn = 1'b1;
    logic       sck = 1'b1;
    logic       din = 1'b0;
    logic       dout;
    logic       reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    logic [4:0] wr_a [1024];
    logic [7:0] wr_v [1024];
    logic [7:0] model [32];

    always #4 clk = ~clk;

    sreg_port i_sreg_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_csn   (csn),
        .ser_clk   (sck),
        .ser_din   (din),
        .ser_dout  (dout),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (wr_cnt < 1024) begin
                wr_a[wr_cnt] = reg_addr;
                wr_v[wr_cnt] = reg_wdata;
            end
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a < 5'd9)       return model[a];
        else if (a == 5'd9) return 8'h19;
        else if (a == 5'd10) return 8'h13;
        else                return 8'h00;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck = 1'b0;
        din = b;
        tick(H);
        r = dout;
        sck = 1'b1;
        tick(H);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 0; i < 8; i++) begin
            logic r;
            xbit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic cs_on();
        csn = 1'b0;
        tick(H);
    endtask

    task automatic cs_off();
        tick(H);
        csn = 1'b1;
        tick(3 * H);
    endtask

    task automatic do_write(input string req, input logic [4:0] start,
                            input logic [7:0] d [8], input int n, input logic [1:0] junk);
        logic [7:0] rx;
        logic [4:0] a;
        logic [4:0] ea [8];
        logic [7:0] ev [8];
        int ne = 0;
        int base = wr_cnt;
        a = start;
        cs_on();
        xbyte({1'b1, junk, start}, rx);
        chk("R8 idle dout during command", {24'd0, rx}, 32'd0);
        for (int k = 0; k < n; k++) begin
            xbyte(d[k], rx);
            chk("R8 dout low in write mode", {24'd0, rx}, 32'd0);
            if (a < 5'd9) begin
                ea[ne] = a;
                ev[ne] = d[k];
                model[a] = d[k];
                ne++;
            end
            a = a + 5'd1;
        end
        cs_off();
        chk({req, " strobe count"}, wr_cnt - base, ne);
        for (int k = 0; k < ne; k++) begin
            chk({req, " strobe address"}, {27'd0, wr_a[base+k]}, {27'd0, ea[k]});
            chk({req, " strobe data"}, {24'd0, wr_v[base+k]}, {24'd0, ev[k]});
        end
    endtask

    task automatic do_read(input string req, input logic [4:0] start, input int n,
                           input logic [1:0] junk);
        logic [7:0] rx;
        logic [4:0] a;
        int base = wr_cnt;
        a = start;
        cs_on();
        xbyte({1'b0, junk, start}, rx);
        for (int k = 0; k < n; k++) begin
            xbyte(8'($urandom), rx);
            chk(req, {24'd0, rx}, {24'd0, exp_read(a)});
            a = a + 5'd1;
        end
        cs_off();
        chk("R4 no strobe in read mode", wr_cnt - base, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d [8];
        logic [7:0] rx;
        int base;
        void'($urandom(32'd4711));
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        model[0] = 8'hFD;
        model[1] = 8'hC0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1: reset state at the ports and register defaults
        chk("R1 dout after reset", {31'd0, dout}, 32'd0);
        chk("R1 strobe after reset", {31'd0, reg_wr}, 32'd0);
        do_read("R1 default readback", 5'd0, 11, 2'b00);

        // R5: identity registers and unimplemented reads, across the wrap
        do_read("R5 identity and empty reads", 5'd9, 4, 2'b00);
        do_read("R5 read wraps to register 0", 5'd31, 2, 2'b00);

        // R2: direction bit and don't-care bits 6:5
        for (int i = 0; i < 8; i++) d[i] = 8'(8'h11 * (i + 1));
        do_write("R2 command with bits 6:5 set", 5'd2, d, 3, 2'b11);
        do_read("R2 readback after junk-bit command", 5'd2, 3, 2'b10);

        // R3: wrap of the address from 31 to 0
        d[0] = 8'hAA; d[1] = 8'h5B;
        do_write("R3 write wraps 31 to 0", 5'd31, d, 2, 2'b00);
        do_read("R3 readback after wrap", 5'd0, 1, 2'b00);

        // R5: writes to read-only and unimplemented addresses are dropped
        d[0] = 8'h00; d[1] = 8'hFF; d[2] = 8'h77;
        do_write("R5 write to read-only range", 5'd9, d, 3, 2'b00);
        do_read("R5 identity unchanged", 5'd9, 3, 2'b00);

        // R6: abort inside the command byte, then a clean write
        cs_on();
        for (int i = 0; i < 4; i++) begin
            logic r;
            xbit(i[0], r);
        end
        cs_off();
        d[0] = 8'h3C;
        do_write("R6 command after aborted command", 5'd4, d, 1, 2'b00);
        // R6: abort inside a data byte gives no write
        base = wr_cnt;
        cs_on();
        xbyte(8'h85, rx);
        for (int i = 0; i < 5; i++) begin
            logic r;
            xbit(1'b1, r);
        end
        cs_off();
        chk("R6 partial data byte discarded", wr_cnt - base, 0);
        do_read("R6 register unchanged after abort", 5'd5, 1, 2'b00);

        // R7: serial activity with chip select high
        base = wr_cnt;
        for (int i = 0; i < 40; i++) begin
            sck = ~sck;
            din = 1'($urandom);
            tick(H);
        end
        sck = 1'b1;
        tick(2 * H);
        chk("R7 no strobe while deselected", wr_cnt - base, 0);
        chk("R8 dout low while deselected", {31'd0, dout}, 32'd0);
        do_read("R7 registers unchanged", 5'd0, 9, 2'b00);

        // R3/R4: random mix of transactions
        for (int t = 0; t < 30; t++) begin
            logic [4:0] st;
            int n;
            st = 5'($urandom % 32);
            n  = 1 + int'($urandom % 6);
            if ($urandom % 2 == 1) begin
                for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
                do_write("R3 random write", st, d, n, 2'($urandom));
            end else begin
                do_read("R4 random read", st, n, 2'($urandom));
            end
        end
        do_read("R4 final full readback", 5'd0, 12, 2'b01);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule